// File: doc/BRIEF.md
# Four-Channel Co-Processor Register File

This block is the memory-mapped register file that sits in front of a four-channel, descriptor-driven crypto co-processor. Software reaches it over a simple 32-bit register bus with one-cycle read and write strobes. Global registers hold the interrupt enables and mode flags, a per-channel completion status with a write-one-to-clear alias, a channel enable mask, a read-only capability word and a context pointer.

Each channel has its own address window at a fixed stride. A window holds a command pointer, which the channel engine fetches from, and a counting semaphore that software bumps to arm the channel. It also holds an error status byte with its own clear alias. The channel engines report back through completion pulses, error pulses with an error code, and semaphore-decrement pulses. The block raises one level interrupt for every completion whose interrupt enable is set.

Read data is registered and follows the read strobe by one clock. The interrupt, command pointers and semaphore counts all come straight from flops.

Top module: `ccr_regfile`

## Requirements
- R1: After synchronous reset every register is zero, `rdata` is 0, `irq` is low, and every `cmd_ptr` and `sema_cnt` lane is 0.
- R2: The control register at 0x000 keeps only bits 23, 22 and [3:0] of a write. Bits [3:0] are the interrupt enables for channels 3..0. All other bits read as 0.
- R3: A pulse on `done_pulse[n]` sets bit n of the status register at 0x010. A write to 0x018 clears exactly the bits set in `wdata[3:0]`. If a set and a clear hit the same bit in the same cycle, the bit stays set.
- R4: `irq` is registered. In each cycle it equals the OR over n of status[n] AND control[n], taken from the register state before the last clock edge.
- R5: The channel enable register at 0x020 holds `wdata[7:0]`. Its other bits read as 0.
- R6: The word at 0x040 always reads `CAP_WORD` (default 0x00050001: bit 0 means AES-128, bit 16 SHA-1, bit 18 SHA-256). Writes to it have no effect.
- R7: The context pointer at 0x050 is a full 32-bit read/write register.
- R8: Channel n occupies 0x100 + n*0x40. Its command pointer at offset 0x00 is 32-bit read/write and drives `cmd_ptr[32n+31:32n]`.
- R9: A write to the semaphore at offset 0x10 adds `wdata[7:0]` to that channel's 8-bit count. `sema_dec[n]` takes one away. The result of a cycle is clamped to the range 0..255. The count reads in bits [7:0] and appears on `sema_cnt[8n+7:8n]`.
- R10: The channel status at offset 0x20 ORs the channel's `err_code` byte into bits [7:0] on each `err_pulse[n]`. A write to offset 0x28 clears the bits set in `wdata[7:0]`, so all ones zeroes it. A set wins over a clear of the same bit in the same cycle.
- R11: Reads of an unmapped offset, of the 0x018 alias or of a channel's 0x28 alias return 0. Writes to unmapped offsets change nothing.
- R12: `rdata` takes the value addressed by `rd_en` at the next clock edge, using the state before that edge, and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| done_pulse | input | NCH | Completion pulse per channel |
| err_pulse | input | NCH | Error pulse per channel |
| err_code | input | NCH*8 | Error code byte per channel |
| sema_dec | input | NCH | Semaphore decrement pulse per channel |
| irq | output | 1 | Level interrupt |
| cmd_ptr | output | NCH*32 | Command pointer per channel |
| sema_cnt | output | NCH*8 | Semaphore count per channel |

## Verification
A corrupted semaphore count shows at once on `sema_cnt`, which is compared every cycle. A lost or stuck completion bit shows on `irq` one cycle later when its enable is set, and on the next read of 0x010. Error bits and global registers are only visible through reads, so random traffic mixes reads into the writes and engine pulses to keep the time between a fault and its detection short. Directed cases cover the same-cycle set-versus-clear races, saturation at both ends of the count, and the alias and unmapped offsets.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  // global register offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_GSTAT  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_GCLR   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_CHCTRL = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CAP    = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_CTX    = 12'h050;

  // channel windows
  localparam logic [ADDR_W-1:0] CH_BASE      = 12'h100;
  localparam int unsigned       CH_STRIDE_LG = 6;
  localparam logic [CH_STRIDE_LG-1:0] CH_CMD  = 6'h00;
  localparam logic [CH_STRIDE_LG-1:0] CH_SEMA = 6'h10;
  localparam logic [CH_STRIDE_LG-1:0] CH_STAT = 6'h20;
  localparam logic [CH_STRIDE_LG-1:0] CH_SCLR = 6'h28;

  localparam logic [DATA_W-1:0] CTRL_MODE_BITS = 32'h00C0_0000;
endpackage

// File: rtl/ccr_global.sv
module ccr_global
  import ccr_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CHEN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_gclr,
  input  logic              wr_chctrl,
  input  logic              wr_ctx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCH-1:0]    done_pulse,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [NCH-1:0]    gstat_q,
  output logic [CHEN_W-1:0] chctrl_q,
  output logic [DATA_W-1:0] ctx_q,
  output logic              irq
);
  localparam logic [DATA_W-1:0] CTRL_WMASK =
    CTRL_MODE_BITS | DATA_W'((64'd1 << NCH) - 64'd1);

  logic [NCH-1:0] clr_mask;
  assign clr_mask = wr_gclr ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      gstat_q  <= '0;
      chctrl_q <= '0;
      ctx_q    <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= wdata & CTRL_WMASK;
      if (wr_chctrl) chctrl_q <= wdata[CHEN_W-1:0];
      if (wr_ctx)    ctx_q    <= wdata;
      // completion set dominates a simultaneous clear
      gstat_q <= (gstat_q & ~clr_mask) | done_pulse;
      irq     <= |(gstat_q & ctrl_q[NCH-1:0]);
    end
  end
endmodule

// File: rtl/ccr_channel.sv
module ccr_channel
  import ccr_pkg::*;
#(
  parameter int unsigned SEMA_W = 8,
  parameter int unsigned ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cmd,
  input  logic              wr_sema,
  input  logic              wr_stat_clr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sema_dec,
  input  logic              err_pulse,
  input  logic [ERR_W-1:0]  err_code,
  output logic [DATA_W-1:0] cmd_q,
  output logic [SEMA_W-1:0] sema_q,
  output logic [ERR_W-1:0]  stat_q
);
  localparam int unsigned       SUM_W    = SEMA_W + 2;
  localparam logic [SUM_W-1:0]  SEMA_MAX = SUM_W'((64'd1 << SEMA_W) - 64'd1);

  logic [SUM_W-1:0]  sum;
  logic [SEMA_W-1:0] sema_d;
  logic [ERR_W-1:0]  stat_clr;

  always_comb begin
    sum = SUM_W'(sema_q) + (wr_sema ? SUM_W'(wdata[SEMA_W-1:0]) : '0);
    if (sema_dec && (sum != '0)) sum = sum - SUM_W'(1);
    sema_d = (sum > SEMA_MAX) ? '1 : sum[SEMA_W-1:0];
  end

  assign stat_clr = wr_stat_clr ? wdata[ERR_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      sema_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= wdata;
      sema_q <= sema_d;
      stat_q <= (stat_q & ~stat_clr) | (err_pulse ? err_code : '0);
    end
  end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
#(
  parameter int unsigned       NCH      = 4,
  parameter int unsigned       SEMA_W   = 8,
  parameter int unsigned       ERR_W    = 8,
  parameter int unsigned       CHEN_W   = 8,
  parameter logic [DATA_W-1:0] CAP_WORD = 32'h0005_0001
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic [NCH-1:0]          done_pulse,
  input  logic [NCH-1:0]          err_pulse,
  input  logic [NCH*ERR_W-1:0]    err_code,
  input  logic [NCH-1:0]          sema_dec,
  output logic                    irq,
  output logic [NCH*DATA_W-1:0]   cmd_ptr,
  output logic [NCH*SEMA_W-1:0]   sema_cnt
);
  localparam int unsigned      CHN_W = ADDR_W - CH_STRIDE_LG;
  localparam logic [CHN_W-1:0] NCH_V = CHN_W'(NCH);

  // address decode
  logic [ADDR_W-1:0]       ch_rel;
  logic [CHN_W-1:0]        ch_num;
  logic [CH_STRIDE_LG-1:0] ch_ofs;
  logic                    ch_hit;

  assign ch_rel = addr - CH_BASE;
  assign ch_num = ch_rel[ADDR_W-1:CH_STRIDE_LG];
  assign ch_ofs = ch_rel[CH_STRIDE_LG-1:0];
  assign ch_hit = (addr >= CH_BASE) && (ch_num < NCH_V);

  // global registers
  logic [DATA_W-1:0] ctrl_q;
  logic [NCH-1:0]    gstat_q;
  logic [CHEN_W-1:0] chctrl_q;
  logic [DATA_W-1:0] ctx_q;

  ccr_global #(.NCH(NCH), .CHEN_W(CHEN_W)) u_global (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (wr_en && (addr == OFS_CTRL)),
    .wr_gclr   (wr_en && (addr == OFS_GCLR)),
    .wr_chctrl (wr_en && (addr == OFS_CHCTRL)),
    .wr_ctx    (wr_en && (addr == OFS_CTX)),
    .wdata     (wdata),
    .done_pulse(done_pulse),
    .ctrl_q    (ctrl_q),
    .gstat_q   (gstat_q),
    .chctrl_q  (chctrl_q),
    .ctx_q     (ctx_q),
    .irq       (irq)
  );

  // channel windows
  logic [DATA_W-1:0] ch_cmd  [NCH];
  logic [SEMA_W-1:0] ch_sema [NCH];
  logic [ERR_W-1:0]  ch_stat [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CHN_W-1:0] IDX = CHN_W'(i);
    logic wsel;
    assign wsel = wr_en && ch_hit && (ch_num == IDX);

    ccr_channel #(.SEMA_W(SEMA_W), .ERR_W(ERR_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_cmd     (wsel && (ch_ofs == CH_CMD)),
      .wr_sema    (wsel && (ch_ofs == CH_SEMA)),
      .wr_stat_clr(wsel && (ch_ofs == CH_SCLR)),
      .wdata      (wdata),
      .sema_dec   (sema_dec[i]),
      .err_pulse  (err_pulse[i]),
      .err_code   (err_code[i*ERR_W +: ERR_W]),
      .cmd_q      (ch_cmd[i]),
      .sema_q     (ch_sema[i]),
      .stat_q     (ch_stat[i])
    );

    assign cmd_ptr[i*DATA_W +: DATA_W]  = ch_cmd[i];
    assign sema_cnt[i*SEMA_W +: SEMA_W] = ch_sema[i];
  end

  // read mux, registered
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CTRL:   rd_mux = ctrl_q;
      OFS_GSTAT:  rd_mux = DATA_W'(gstat_q);
      OFS_CHCTRL: rd_mux = DATA_W'(chctrl_q);
      OFS_CAP:    rd_mux = CAP_WORD;
      OFS_CTX:    rd_mux = ctx_q;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (ch_hit && (ch_num == CHN_W'(i))) begin
            case (ch_ofs)
              CH_CMD:  rd_mux = ch_cmd[i];
              CH_SEMA: rd_mux = DATA_W'(ch_sema[i]);
              CH_STAT: rd_mux = DATA_W'(ch_stat[i]);
              default: rd_mux = '0;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
#(
  parameter int unsigned       NCH      = 4,
  parameter int unsigned       SEMA_W   = 8,
  parameter logic [DATA_W-1:0] CAP_WORD = 32'h0005_0001
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     rdata,
  input logic [NCH-1:0]        done_pulse,
  input logic [NCH-1:0]        sema_dec,
  input logic [NCH-1:0]        gstat,
  input logic [NCH-1:0]        ctrl_ie,
  input logic                  irq,
  input logic [NCH*SEMA_W-1:0] sema_cnt
);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(256 + NCH*64);

  logic mapped;
  always_comb begin
    mapped = (addr == 12'h000) || (addr == 12'h010) || (addr == 12'h020) ||
             (addr == 12'h040) || (addr == 12'h050) ||
             ((addr >= 12'h100) && (addr < WIN_END) &&
              ((addr[5:0] == 6'h00) || (addr[5:0] == 6'h10) ||
               (addr[5:0] == 6'h20)));
  end

  // R1: reset leaves the outputs quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq && (sema_cnt == '0) && (rdata == '0)));

  // R4: no enabled completion pending means no interrupt next cycle
  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (rst)
    ((gstat & ctrl_ie) == '0) |=> !irq);

  assert_irq_raised_R4: assert property (@(posedge clk) disable iff (rst)
    ((gstat & ctrl_ie) != '0) |=> irq);

  // R6: capability word is constant
  assert_cap_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == 12'h040)) |=> (rdata == CAP_WORD));

  // R11: unmapped and alias reads are zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rdata == '0));

  // R12: read data holds without a strobe
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic sema_wr;
    assign sema_wr = wr_en && (addr == ADDR_W'(256 + i*64 + 16));

    // R3: completion always lands
    assert_done_sets_R3: assert property (@(posedge clk) disable iff (rst)
      done_pulse[i] |=> gstat[i]);

    // R9: floor at zero and no drift when idle
    assert_sema_floor_R9: assert property (@(posedge clk) disable iff (rst)
      ((sema_cnt[i*SEMA_W +: SEMA_W] == '0) && sema_dec[i] && !sema_wr)
      |=> (sema_cnt[i*SEMA_W +: SEMA_W] == '0));

    assert_sema_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (!sema_dec[i] && !sema_wr) |=> $stable(sema_cnt[i*SEMA_W +: SEMA_W]));
  end
endmodule

bind ccr_regfile ccr_checker #(
  .NCH     (NCH),
  .SEMA_W  (SEMA_W),
  .CAP_WORD(CAP_WORD)
) u_ccr_checker (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .done_pulse(done_pulse),
  .sema_dec  (sema_dec),
  .gstat     (gstat_q),
  .ctrl_ie   (ctrl_q[NCH-1:0]),
  .irq       (irq),
  .sema_cnt  (sema_cnt)
);

// File: tb/test_ccr_regfile.sv
module test_ccr_regfile;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  done_pulse = '0, err_pulse = '0, sema_dec = '0;
  logic [31:0] err_code = '0;
  logic        irq;
  logic [127:0] cmd_ptr;
  logic [31:0]  sema_cnt;

  ccr_regfile i_ccr_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done_pulse(done_pulse),
    .err_pulse(err_pulse), .err_code(err_code), .sema_dec(sema_dec),
    .irq(irq), .cmd_ptr(cmd_ptr), .sema_cnt(sema_cnt)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_ctrl, m_ctx, m_rdata;
  logic [3:0]  m_gstat;
  logic [7:0]  m_chctrl;
  logic [31:0] m_cmd [NCH];
  int          m_sema [NCH];
  logic [7:0]  m_stat [NCH];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] chb(int i);
    return 12'(256 + i*64);
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h000: return m_ctrl;
      12'h010: return {28'd0, m_gstat};
      12'h020: return {24'd0, m_chctrl};
      12'h040: return 32'h0005_0001;
      12'h050: return m_ctx;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (a == chb(i))         return m_cmd[i];
      if (a == chb(i) + 12'h10) return 32'(m_sema[i]);
      if (a == chb(i) + 12'h20) return {24'd0, m_stat[i]};
    end
    return 32'd0;
  endfunction

  function automatic string tag(logic [11:0] a);
    case (a)
      12'h000: return "R2";
      12'h010: return "R3";
      12'h020: return "R5";
      12'h040: return "R6";
      12'h050: return "R7";
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (a == chb(i))          return "R8";
      if (a == chb(i) + 12'h10) return "R9";
      if (a == chb(i) + 12'h20) return "R10";
    end
    return "R11";
  endfunction

  task automatic model_update(bit wr, logic [11:0] a, logic [31:0] d,
                              logic [3:0] dn, logic [3:0] er,
                              logic [31:0] ec, logic [3:0] dc);
    logic [3:0] gclr;
    if (wr && a == 12'h000) m_ctrl = d & 32'h00C0_000F;
    if (wr && a == 12'h020) m_chctrl = d[7:0];
    if (wr && a == 12'h050) m_ctx = d;
    gclr = (wr && a == 12'h018) ? d[3:0] : 4'h0;
    m_gstat = (m_gstat & ~gclr) | dn;
    for (int i = 0; i < NCH; i++) begin
      int s;
      logic [7:0] sclr;
      if (wr && a == chb(i)) m_cmd[i] = d;
      s = m_sema[i] + ((wr && a == chb(i) + 12'h10) ? int'(d[7:0]) : 0);
      if (dc[i]) s = s - 1;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      m_sema[i] = s;
      sclr = (wr && a == chb(i) + 12'h28) ? d[7:0] : 8'h0;
      m_stat[i] = (m_stat[i] & ~sclr) | (er[i] ? ec[8*i +: 8] : 8'h0);
    end
  endtask

  // one clock of stimulus, entered and left just after a falling edge
  task automatic step(bit wr, bit rd, logic [11:0] a, logic [31:0] d,
                      logic [3:0] dn, logic [3:0] er, logic [31:0] ec,
                      logic [3:0] dc);
    bit exp_irq;
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    done_pulse = dn; err_pulse = er; err_code = ec; sema_dec = dc;
    exp_irq = |(m_gstat & m_ctrl[3:0]);
    if (rd) m_rdata = model_read(a);
    model_update(wr, a, d, dn, er, ec, dc);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; done_pulse = '0; err_pulse = '0; sema_dec = '0;
    chk(rd ? tag(a) : "R12", "rdata", rdata, m_rdata);
    chk("R4", "irq", 32'(irq), 32'(exp_irq));
    for (int i = 0; i < NCH; i++) begin
      chk("R9", "sema_cnt", 32'(sema_cnt[8*i +: 8]), 32'(m_sema[i]));
      chk("R8", "cmd_ptr", cmd_ptr[32*i +: 32], m_cmd[i]);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    step(1, 0, a, d, '0, '0, '0, '0);
  endtask

  task automatic rd(logic [11:0] a);
    step(0, 1, a, '0, '0, '0, '0, '0);
  endtask

  function automatic logic [11:0] pick_addr();
    int r;
    r = int'($urandom % 12);
    case (r)
      0: return 12'h000;
      1: return 12'h010;
      2: return 12'h018;
      3: return 12'h020;
      4: return 12'h040;
      5: return 12'h050;
      10: return 12'($urandom);
      11: return {$urandom % 10 == 0 ? 4'h2 : 4'h1, 8'($urandom)} & 12'hFFC;
      default: begin
        int c;
        int o;
        c = int'($urandom % NCH);
        o = int'($urandom % 4);
        return chb(c) + (o == 0 ? 12'h00 : o == 1 ? 12'h10 : o == 2 ? 12'h20 : 12'h28);
      end
    endcase
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    m_ctrl = '0; m_ctx = '0; m_rdata = '0; m_gstat = '0; m_chctrl = '0;
    for (int i = 0; i < NCH; i++) begin
      m_cmd[i] = '0; m_sema[i] = 0; m_stat[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1", "rdata after reset", rdata, 32'h0);
    chk("R1", "irq after reset", 32'(irq), 32'h0);
    chk("R1", "sema_cnt after reset", sema_cnt, 32'h0);
    chk("R1", "cmd_ptr after reset", cmd_ptr[31:0] | cmd_ptr[63:32] |
        cmd_ptr[95:64] | cmd_ptr[127:96], 32'h0);
    rd(12'h000); rd(12'h010); rd(12'h050); rd(12'h160);

    // R2: control keeps only its defined bits
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000);
    chk("R2", "ctrl mask", rdata, 32'h00C0_000F);
    wr(12'h000, 32'h0);

    // R5: channel enables
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020);
    chk("R5", "chctrl mask", rdata, 32'h0000_00FF);

    // R6: capability is read-only
    wr(12'h040, 32'h0); rd(12'h040);
    chk("R6", "cap word", rdata, 32'h0005_0001);

    // R7: context pointer
    wr(12'h050, 32'hFFFF_0000); rd(12'h050);
    chk("R7", "ctx", rdata, 32'hFFFF_0000);

    // R3: set, set-beats-clear, clear
    step(0, 0, 12'h0, 0, 4'b0010, '0, '0, '0);
    rd(12'h010);
    chk("R3", "status set", rdata, 32'h2);
    step(1, 0, 12'h018, 32'h2, 4'b0010, '0, '0, '0);
    rd(12'h010);
    chk("R3", "set wins over clear", rdata, 32'h2);
    wr(12'h018, 32'hF); rd(12'h010);
    chk("R3", "status cleared", rdata, 32'h0);
    rd(12'h018);
    chk("R11", "clear alias reads zero", rdata, 32'h0);

    // R4: interrupt follows enabled status one cycle late
    wr(12'h000, 32'h1);
    step(0, 0, 12'h0, 0, 4'b0100, '0, '0, '0);
    step(0, 0, 12'h0, 0, '0, '0, '0, '0);
    chk("R4", "masked channel no irq", 32'(irq), 32'h0);
    step(0, 0, 12'h0, 0, 4'b0001, '0, '0, '0);
    chk("R4", "irq not yet", 32'(irq), 32'h0);
    step(0, 0, 12'h0, 0, '0, '0, '0, '0);
    chk("R4", "irq raised", 32'(irq), 32'h1);
    wr(12'h018, 32'hF);
    step(0, 0, 12'h0, 0, '0, '0, '0, '0);
    chk("R4", "irq dropped", 32'(irq), 32'h0);

    // R8: command pointer of channel 1
    wr(12'h140, 32'hDEAD_BEEF);
    chk("R8", "cmd_ptr ch1", cmd_ptr[63:32], 32'hDEAD_BEEF);
    rd(12'h140);

    // R9: saturation at the top, floor at zero, add with decrement
    wr(12'h190, 32'hFF); wr(12'h190, 32'h10);
    chk("R9", "sema saturates high", 32'(sema_cnt[23:16]), 32'd255);
    wr(12'h110, 32'h3);
    repeat (5) step(0, 0, 12'h0, 0, '0, '0, '0, 4'b0001);
    chk("R9", "sema floor", 32'(sema_cnt[7:0]), 32'd0);
    step(1, 0, 12'h1D0, 32'h5, '0, '0, '0, 4'b1000);
    chk("R9", "add with decrement", 32'(sema_cnt[31:24]), 32'd4);
    rd(12'h1D0);

    // R10: error byte, set beats clear, full clear
    step(0, 0, 12'h0, 0, '0, 4'b0010, 32'h0000_A500, '0);
    rd(12'h160);
    chk("R10", "err set", rdata, 32'hA5);
    step(1, 0, 12'h168, 32'hFFFF_FFFF, '0, 4'b0010, 32'h0000_0100, '0);
    rd(12'h160);
    chk("R10", "err set wins", rdata, 32'h01);
    wr(12'h168, 32'hFFFF_FFFF); rd(12'h160);
    chk("R10", "err cleared", rdata, 32'h0);

    // R11: unmapped accesses
    wr(12'h004, 32'hFFFF_FFFF); wr(12'h1F0, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h004); chk("R11", "unmapped 0x004", rdata, 32'h0);
    rd(12'h200); chk("R11", "beyond windows", rdata, 32'h0);
    rd(12'h128); chk("R11", "channel clear alias", rdata, 32'h0);

    // R12: hold without strobe
    rd(12'h040);
    step(0, 0, 12'h050, 0, '0, '0, '0, '0);
    chk("R12", "rdata held", rdata, 32'h0005_0001);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit          w, r;
      logic [3:0]  dn, er, dc;
      w  = ($urandom % 3) == 0;
      r  = ($urandom % 2) == 0;
      dn = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
      er = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      dc = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      step(w, r, pick_addr(), (($urandom % 4) == 0) ? 32'($urandom % 4) : $urandom,
           dn, er, $urandom, dc);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule